// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block serves one processor and supports atomic read-modify-write sequences built from a load-linked and a store-conditional. A load-linked reads a word from a local word-addressed memory and opens a reservation on the 64-byte block that holds the address. A later store-conditional writes its word and answers 1 only when the reservation is still open and covers the same block. In every other case it leaves memory untouched and answers 0, and software goes back to the load-linked to try again.

The reservation is not closed by this processor's own plain stores. Two kinds of outside events close it. The first is a coherence invalidation, shown on an address input whenever another processor's write removes a block from this processor's cache. The second is an interrupt or context-switch pulse. Any store-conditional also closes the reservation, whether it succeeds or not, and a new load-linked replaces whatever reservation was open before. The cache itself sits outside the block. Each request is accepted in one cycle and produces exactly one response in the next cycle.

Top module: `atomic_link_monitor`

## Requirements
- R1: Each cycle with `req_valid` high produces `rsp_valid` high in the next cycle, and only then.
- R2: Operation codes on `req_op` are 00 plain load, 01 plain store, 10 load-linked and 11 store-conditional. Byte address bits [1:0] are ignored. A load returns the stored word. A store writes its word and answers with data 0.
- R3: A load-linked returns the stored word and opens a reservation on block address bits [8:6]. It replaces any earlier reservation.
- R4: A store-conditional whose block matches an open reservation writes memory and answers 1, whichever word within the block it targets.
- R5: A store-conditional with no open reservation, or with a different block, answers 0 and leaves memory unchanged.
- R6: Every store-conditional closes the reservation, so a second one without a new load-linked fails.
- R7: `irq_event` closes the reservation. In the same cycle as a store-conditional it makes that store fail. In the same cycle as a load-linked it stops the reservation from opening.
- R8: An invalidation whose block equals the reserved block closes the reservation, and it also does so in the same cycle as a store-conditional. An invalidation in the same cycle as a load-linked to the same block stops the reservation from opening. An invalidation of any other block has no effect.
- R9: Plain loads and stores, including stores into the reserved block, leave the reservation unchanged.
- R10: After reset no reservation is open and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code |
| req_addr | input | ADDR_W (9) | Byte address |
| req_wdata | input | DATA_W (32) | Store data |
| inv_valid | input | 1 | Coherence invalidation present this cycle |
| inv_addr | input | ADDR_W (9) | Address inside the invalidated block |
| irq_event | input | 1 | Interrupt or context-switch pulse |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DATA_W (32) | Load data, or 0/1 result of a store-conditional |

## Verification
The hardest situations to reach are the ones where a closing event lands in exactly the same cycle as the load-linked or the store-conditional it competes with, and where the invalidated block differs from the reserved one by a single block bit. Directed sequences drive each of these collisions on their own. A long random run then keeps addresses within eight blocks and a few words per block, and raises invalidations and interrupts often. This makes matching blocks, reopened reservations and colliding events come up thousands of times, and every response is compared with a bench model.

// File: rtl/alm_pkg.sv
package alm_pkg;

  typedef enum logic [1:0] {
    OP_LOAD       = 2'b00,
    OP_STORE      = 2'b01,
    OP_LINK_LOAD  = 2'b10,
    OP_COND_STORE = 2'b11
  } alm_op_e;

  typedef enum logic [1:0] {
    RSP_ZERO = 2'b00,
    RSP_WORD = 2'b01,
    RSP_FLAG = 2'b10
  } alm_rsp_e;

endpackage

// File: rtl/alm_link_reg.sv
module alm_link_reg #(
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ll_fire,
  input  logic             sc_fire,
  input  logic [BLK_W-1:0] req_blk,
  input  logic             inv_fire,
  input  logic [BLK_W-1:0] inv_blk,
  input  logic             irq,
  output logic             sc_pass
);

  logic             resv_q, resv_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             blk_en;
  logic             inv_hits_resv;
  logic             inv_hits_req;
  logic             open_ok;

  // Coherence kill of the current reservation, and of one being opened now
  assign inv_hits_resv = inv_fire && (inv_blk == blk_q);
  assign inv_hits_req  = inv_fire && (inv_blk == req_blk);
  assign open_ok       = ll_fire && !irq && !inv_hits_req;

  // Same-cycle closing events take priority over the conditional store
  assign sc_pass = resv_q && (blk_q == req_blk) && !irq && !inv_hits_resv;

  always_comb begin
    resv_d = resv_q;
    blk_d  = blk_q;
    blk_en = 1'b0;
    if (sc_fire || irq || inv_hits_resv) begin
      resv_d = 1'b0;
    end
    if (open_ok) begin
      resv_d = 1'b1;
      blk_d  = req_blk;
      blk_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_q <= 1'b0;
      blk_q  <= '0;
    end else begin
      resv_q <= resv_d;
      if (blk_en) begin
        blk_q <= blk_d;
      end
    end
  end

  a_r7_irq_clears : assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !resv_q);

  a_r6_sc_clears : assert property (@(posedge clk) disable iff (!rst_n)
    (sc_fire && !ll_fire) |=> !resv_q);

  a_r8_inv_clears : assert property (@(posedge clk) disable iff (!rst_n)
    (inv_fire && resv_q && (inv_blk == blk_q) && !ll_fire) |=> !resv_q);

  a_r3_ll_records : assert property (@(posedge clk) disable iff (!rst_n)
    (ll_fire && !irq && !(inv_fire && (inv_blk == req_blk)))
      |=> (resv_q && (blk_q == $past(req_blk))));

  a_r9_quiet_holds : assert property (@(posedge clk) disable iff (!rst_n)
    (!ll_fire && !sc_fire && !irq && !inv_fire)
      |=> ($stable(resv_q) && $stable(blk_q)));

endmodule

// File: rtl/alm_word_store.sv
module alm_word_store #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 128,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] cells [WORDS];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_q <= cells[rd_idx];
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/atomic_link_monitor.sv
module atomic_link_monitor
  import alm_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int MEM_WORDS   = 128,
  parameter int BLOCK_BYTES = 64,
  localparam int BYTES_W    = DATA_W / 8,
  localparam int OFF_W      = $clog2(BYTES_W),
  localparam int ADDR_W     = $clog2(MEM_WORDS * BYTES_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic              irq_event,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int IDX_W   = $clog2(MEM_WORDS);
  localparam int BLK_OFF = $clog2(BLOCK_BYTES);
  localparam int BLK_W   = ADDR_W - BLK_OFF;

  // Reset: asserted at once, released after two clock edges
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  alm_op_e            op;
  logic [IDX_W-1:0]   word_idx;
  logic [BLK_W-1:0]   req_blk, inv_blk;
  logic               ll_fire, sc_fire, ld_fire, st_fire;
  logic               sc_pass;
  logic               mem_we, mem_re;
  logic [DATA_W-1:0]  mem_rdata;
  logic               unused_low_bits;

  assign op       = alm_op_e'(req_op);
  assign word_idx = req_addr[ADDR_W-1:OFF_W];
  assign req_blk  = req_addr[ADDR_W-1:BLK_OFF];
  assign inv_blk  = inv_addr[ADDR_W-1:BLK_OFF];
  assign unused_low_bits = ^{req_addr[OFF_W-1:0], inv_addr[BLK_OFF-1:0]};

  assign ld_fire = req_valid && (op == OP_LOAD);
  assign st_fire = req_valid && (op == OP_STORE);
  assign ll_fire = req_valid && (op == OP_LINK_LOAD);
  assign sc_fire = req_valid && (op == OP_COND_STORE);

  assign mem_we  = st_fire || (sc_fire && sc_pass);
  assign mem_re  = ld_fire || ll_fire;

  alm_link_reg #(.BLK_W(BLK_W)) i_link (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .ll_fire  (ll_fire),
    .sc_fire  (sc_fire),
    .req_blk  (req_blk),
    .inv_fire (inv_valid),
    .inv_blk  (inv_blk),
    .irq      (irq_event),
    .sc_pass  (sc_pass)
  );

  alm_word_store #(.DATA_W(DATA_W), .WORDS(MEM_WORDS)) i_store (
    .clk     (clk),
    .wr_en   (mem_we),
    .wr_idx  (word_idx),
    .wr_data (req_wdata),
    .rd_en   (mem_re),
    .rd_idx  (word_idx),
    .rd_data (mem_rdata)
  );

  // Response stage: next-state logic
  logic     rsp_valid_q, rsp_valid_d;
  alm_rsp_e rsp_kind_q, rsp_kind_d;
  logic     flag_q, flag_d;
  logic     rsp_en;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_en      = req_valid;
    rsp_kind_d  = RSP_ZERO;
    flag_d      = 1'b0;
    if (mem_re) begin
      rsp_kind_d = RSP_WORD;
    end else if (sc_fire) begin
      rsp_kind_d = RSP_FLAG;
      flag_d     = sc_pass;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      rsp_valid_q <= 1'b0;
      rsp_kind_q  <= RSP_ZERO;
      flag_q      <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (rsp_en) begin
        rsp_kind_q <= rsp_kind_d;
        flag_q     <= flag_d;
      end
    end
  end

  always_comb begin
    case (rsp_kind_q)
      RSP_WORD: rsp_rdata = mem_rdata;
      RSP_FLAG: rsp_rdata = {{(DATA_W-1){1'b0}}, flag_q};
      default:  rsp_rdata = '0;
    endcase
  end

  assign rsp_valid = rsp_valid_q;

  a_r1_rsp_follows : assert property (@(posedge clk) disable iff (!rst_sync_q)
    req_valid |=> rsp_valid);

  a_r1_no_spurious : assert property (@(posedge clk) disable iff (!rst_sync_q)
    !req_valid |=> !rsp_valid);

  a_r5_fail_answers_zero : assert property (@(posedge clk) disable iff (!rst_sync_q)
    (sc_fire && !sc_pass) |=> (rsp_rdata == '0));

endmodule

// File: tb/test_atomic_link_monitor.sv
`timescale 1ns/1ps
module test_atomic_link_monitor;

  localparam int DW = 32;
  localparam int AW = 9;
  localparam int NW = 128;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          inv_valid;
  logic [AW-1:0] inv_addr;
  logic          irq_event;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  logic [DW-1:0] m_mem [NW];
  logic          m_rv;
  logic [2:0]    m_rb;

  always #2.5 clk = ~clk;

  atomic_link_monitor i_atomic_link_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .inv_valid(inv_valid),
    .inv_addr(inv_addr), .irq_event(irq_event), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected response per requirements; updates the model state
  function automatic logic [DW-1:0] model_step(input logic [1:0] op, input logic [AW-1:0] a,
      input logic [DW-1:0] wd, input logic iv, input logic [AW-1:0] ia, input logic iq);
    logic [DW-1:0] exp;
    logic [2:0]    blk = a[8:6];
    logic [6:0]    w   = a[8:2];
    logic          kill = iq || (iv && m_rv && (ia[8:6] == m_rb));
    logic          ok;
    exp = '0;
    case (op)
      2'b00: exp = m_mem[w];
      2'b01: m_mem[w] = wd;
      2'b10: exp = m_mem[w];
      default: begin
        ok = m_rv && (m_rb == blk) && !kill;
        if (ok) m_mem[w] = wd;
        exp = {31'b0, ok};
      end
    endcase
    if (op == 2'b11 || kill) m_rv = 1'b0;
    if (op == 2'b10 && !iq && !(iv && ia[8:6] == blk)) begin
      m_rv = 1'b1;
      m_rb = blk;
    end
    return exp;
  endfunction

  task automatic run_op(input string req, input logic [1:0] op, input logic [AW-1:0] a,
      input logic [DW-1:0] wd, input logic iv, input logic [AW-1:0] ia, input logic iq);
    logic [DW-1:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    inv_valid = iv; inv_addr = ia; irq_event = iq;
    exp = model_step(op, a, wd, iv, ia, iq);
    @(posedge clk);
    #1;
    check({req, " R1"}, {31'b0, rsp_valid}, 32'd1);
    check(req, rsp_rdata, exp);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; inv_valid = 1'b0; irq_event = 1'b0;
    @(posedge clk);
    #1;
    check("R1 idle", {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_addr = '0; req_wdata = '0;
    inv_valid = 1'b0; inv_addr = '0; irq_event = 1'b0;
    m_rv = 1'b0; m_rb = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R10 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);

    // Fill memory so every word is known
    for (int i = 0; i < NW; i++) run_op("R2 fill", 2'b01, AW'(i * 4), 32'hA500_0000 + i, 0, '0, 0);

    run_op("R10 no reservation after reset", 2'b11, 9'h040, 32'h1111, 0, '0, 0);
    run_op("R5 memory kept", 2'b00, 9'h040, '0, 0, '0, 0);
    run_op("R2 low bits ignored", 2'b00, 9'h043, '0, 0, '0, 0);

    run_op("R3 ll data", 2'b10, 9'h084, '0, 0, '0, 0);
    run_op("R4 sc other word same block", 2'b11, 9'h0B8, 32'hCAFE0001, 0, '0, 0);
    run_op("R4 sc wrote", 2'b00, 9'h0B8, '0, 0, '0, 0);
    run_op("R6 second sc fails", 2'b11, 9'h084, 32'hDEAD, 0, '0, 0);

    run_op("R3 ll", 2'b10, 9'h004, '0, 0, '0, 0);
    run_op("R5 sc other block", 2'b11, 9'h044, 32'hBAD0, 0, '0, 0);
    run_op("R5 unchanged", 2'b00, 9'h044, '0, 0, '0, 0);

    run_op("R3 ll first", 2'b10, 9'h004, '0, 0, '0, 0);
    run_op("R3 ll overwrite", 2'b10, 9'h1C0, '0, 0, '0, 0);
    run_op("R3 sc old block fails", 2'b11, 9'h004, 32'h1, 0, '0, 0);

    run_op("R7 ll", 2'b10, 9'h100, '0, 0, '0, 0);
    idle();
    run_op("R7 irq between", 2'b00, 9'h000, '0, 0, '0, 1);
    run_op("R7 sc after irq", 2'b11, 9'h100, 32'h2, 0, '0, 0);
    run_op("R7 ll", 2'b10, 9'h100, '0, 0, '0, 0);
    run_op("R7 irq with sc", 2'b11, 9'h100, 32'h3, 0, '0, 1);
    run_op("R7 irq with ll", 2'b10, 9'h100, '0, 0, '0, 1);
    run_op("R7 sc after blocked ll", 2'b11, 9'h100, 32'h4, 0, '0, 0);

    run_op("R8 ll", 2'b10, 9'h140, '0, 0, '0, 0);
    run_op("R8 inv neighbour block", 2'b00, 9'h000, '0, 1, 9'h100, 0);
    run_op("R8 sc survives other inv", 2'b11, 9'h17C, 32'h5, 0, '0, 0);
    run_op("R8 ll", 2'b10, 9'h140, '0, 0, '0, 0);
    run_op("R8 inv same block", 2'b00, 9'h000, '0, 1, 9'h17F, 0);
    run_op("R8 sc after inv", 2'b11, 9'h140, 32'h6, 0, '0, 0);
    run_op("R8 ll", 2'b10, 9'h140, '0, 0, '0, 0);
    run_op("R8 inv with sc", 2'b11, 9'h140, 32'h7, 1, 9'h150, 0);
    run_op("R8 inv with ll", 2'b10, 9'h140, '0, 1, 9'h140, 0);
    run_op("R8 sc after blocked ll", 2'b11, 9'h140, 32'h8, 0, '0, 0);

    run_op("R9 ll", 2'b10, 9'h0C0, '0, 0, '0, 0);
    run_op("R9 plain store same block", 2'b01, 9'h0C4, 32'h9, 0, '0, 0);
    run_op("R9 plain load", 2'b00, 9'h0C4, '0, 0, '0, 0);
    run_op("R9 sc still passes", 2'b11, 9'h0C0, 32'hA, 0, '0, 0);

    // Random phase: few blocks, frequent events
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < 3000; k++) begin
      logic [1:0]    op = 2'($urandom % 4);
      logic [AW-1:0] a  = {3'($urandom % 8), 4'($urandom % 4), 2'($urandom % 4)};
      logic          iv = ($urandom % 100) < 15;
      logic [AW-1:0] ia = AW'($urandom);
      logic          iq = ($urandom % 100) < 5;
      if (($urandom % 8) == 0) idle();
      run_op("R4/R5/R7/R8 random", op, a, $urandom, iv, ia, iq);
    end
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule